// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Ganged Row-Buffer Arrays

This block joins a request-side controller to a behavioural model of several identical DRAM arrays that together serve one wide word. Each array stores a grid of small cells arranged in rows and columns. Its only address input is a narrow bus that carries the row number in one command cycle and the column number in a later one. A request arrives with a flat cell index. The controller splits the index into a row and a column. It opens the row, which copies the whole row into the array's internal row buffer, and then reads or writes one cell through that buffer. All lanes receive the same commands. Lane i carries word bits i*LANE_W up to i*LANE_W+LANE_W-1.

A row stays open after an access. A later request to the same row therefore skips the row phase and issues only a column command. Writes change only the row buffer. The buffer is written back into the array before another row opens and before a refresh. A free-running interval counter requests a refresh. A pending refresh is served before any new request, and the refresh leaves every row closed. The command outputs are brought out so the sequencing can be observed.

Top module: `mux_dram_top`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, all four command strobes are 0, and no row is open. The first access therefore shows a row strobe before its column strobe.
- R2: The upper ROW_W bits of req_index select the row and the lower COL_W bits select the column. addr_bus carries the row during row_strobe and the column during col_strobe. At most one of row_strobe, col_strobe, wb_strobe and ref_strobe is high in any cycle.
- R3: A read gives exactly one rsp_valid pulse, in the cycle right after its col_strobe cycle, with rsp_rdata equal to the word last written at that index.
- R4: A write stores the full WORD_W-bit word, and every lane keeps its own slice. A later read of the same index returns the whole word.
- R5: A request to the row that is already open issues no row_strobe and no wb_strobe. Its col_strobe appears in the first cycle after acceptance.
- R6: A request to a different row while a row is open issues wb_strobe, then row_strobe, then col_strobe, in consecutive cycles. Data written to the old row is still returned after the row change.
- R7: req_ready is high only while the controller is idle with no refresh pending. It is low in the cycle after a request is accepted.
- R8: ref_strobe pulses at least once every REFRESH_INTERVAL+6 cycles. If a row is open, wb_strobe comes in the cycle before ref_strobe. The first access after a refresh begins with row_strobe.
- R9: When a refresh is pending and a request is waiting in the same idle cycle, the refresh goes first. The waiting request is accepted afterwards and completes with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | IDX_W | Flat cell index, row in upper bits |
| req_wdata | input | WORD_W | Write word |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | WORD_W | Read word |
| row_strobe | output | 1 | Row-open command |
| col_strobe | output | 1 | Column access command |
| wb_strobe | output | 1 | Row-buffer write-back (row close) command |
| ref_strobe | output | 1 | Refresh command |
| addr_bus | output | BUS_W | Shared row/column address |

## Verification
Refresh and the request handshake compete for the same idle cycle. Such a collision arises when the interval counter expires during a busy access or while a request is being offered. The bench keeps req_valid asserted back to back through a long mixed stream, so the expiry is bound to land where a request is waiting. The bench counts how often ref_strobe is seen while req_valid is still held. At each such event it checks that the write-back came first when a row was open, that the next access re-opens its row, and that the delayed request still returns the modelled data.

// File: rtl/mux_dram_pkg.sv
// Shared types and helpers for the multiplexed-address DRAM block.
// Assumes nothing beyond IEEE 1800-2017 package semantics.
package mux_dram_pkg;

    // Controller command phases; one command per non-idle state.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_COL  = 3'd2,
        ST_WB   = 3'd3,
        ST_REF  = 3'd4
    } phase_t;

    // Larger of two widths, used to size the shared address bus.
    function automatic int unsigned wmax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mux_dram_array.sv
// One behavioural DRAM lane: ROWS x COLS cells of W bits plus a row buffer.
// A row command loads the row buffer from the array. A column command reads
// one buffered cell into dout or writes din into the buffer. A write-back
// command copies the buffer into the array at the row that was opened.
// Assumes the controller never issues a column command with no open row.
module mux_dram_array #(
    parameter int unsigned ROWS  = 4,
    parameter int unsigned COLS  = 4,
    parameter int unsigned W     = 8,
    parameter int unsigned BUS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_cmd,
    input  logic             col_cmd,
    input  logic             wb_cmd,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] addr,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout
);
    localparam int unsigned ROW_W = $clog2(ROWS);
    localparam int unsigned COL_W = $clog2(COLS);

    logic [W-1:0]     cells   [ROWS][COLS];
    logic [W-1:0]     row_buf [COLS];
    logic [ROW_W-1:0] buf_row;

    // Cell storage: updated only by write-back of the row buffer.
    always_ff @(posedge clk) begin
        if (wb_cmd) begin
            for (int c = 0; c < int'(COLS); c++) begin
                cells[buf_row][c] <= row_buf[c];
            end
        end
    end

    // Row buffer: loaded whole on a row command, one cell on a column write.
    always_ff @(posedge clk) begin
        if (row_cmd) begin
            for (int c = 0; c < int'(COLS); c++) begin
                row_buf[c] <= cells[addr[ROW_W-1:0]][c];
            end
        end else if (col_cmd && wr_en) begin
            row_buf[addr[COL_W-1:0]] <= din;
        end
    end

    // Buffered row number and read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_row <= '0;
            dout    <= '0;
        end else begin
            if (row_cmd) begin
                buf_row <= addr[ROW_W-1:0];
            end
            if (col_cmd && !wr_en) begin
                dout <= row_buf[addr[COL_W-1:0]];
            end
        end
    end
endmodule

// File: rtl/mux_dram_refresh.sv
// Refresh interval timer. Raises a pending flag every INTERVAL cycles and
// holds it until the controller reports that the refresh was issued.
// Assumes INTERVAL is well above the longest access sequence.
module mux_dram_refresh #(
    parameter int unsigned INTERVAL = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_done,
    output logic ref_pending
);
    localparam int unsigned CNT_W = $clog2(INTERVAL);

    logic [CNT_W-1:0] tick_cnt;
    logic             expire;

    assign expire = (tick_cnt == CNT_W'(INTERVAL - 1));

    // Free-running interval count.
    always_ff @(posedge clk) begin
        if (!rst_n || expire) begin
            tick_cnt <= '0;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

    // Pending flag: set on expiry, cleared when the refresh is done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_pending <= 1'b0;
        end else if (expire) begin
            ref_pending <= 1'b1;
        end else if (ref_done) begin
            ref_pending <= 1'b0;
        end
    end
endmodule

// File: rtl/mux_dram_ctrl.sv
// Command sequencer. It accepts a request in idle and splits the index into
// a row and a column. It then issues, in order, write-back (if another row
// is open), row open (if the needed row is not open) and column access.
// A pending refresh wins over a new request and closes any open row first.
// Assumes the request fields stay stable while req_valid is high.
module mux_dram_ctrl
    import mux_dram_pkg::*;
#(
    parameter int unsigned ROW_W = 2,
    parameter int unsigned COL_W = 2,
    parameter int unsigned BUS_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ROW_W+COL_W-1:0] req_index,
    input  logic                   ref_pending,
    output logic                   ref_done,
    output logic                   row_cmd,
    output logic                   col_cmd,
    output logic                   wb_cmd,
    output logic                   wr_en,
    output logic [BUS_W-1:0]       addr,
    output logic                   rsp_valid
);
    phase_t           state;
    logic             row_open;
    logic [ROW_W-1:0] open_row;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;
    logic             cur_we;
    logic             serving;
    logic             accept;
    logic [ROW_W-1:0] in_row;

    assign in_row    = req_index[ROW_W+COL_W-1:COL_W];
    assign req_ready = (state == ST_IDLE) && !ref_pending;
    assign accept    = req_ready && req_valid;
    assign row_cmd   = (state == ST_ROW);
    assign col_cmd   = (state == ST_COL);
    assign wb_cmd    = (state == ST_WB);
    assign ref_done  = (state == ST_REF);
    assign wr_en     = cur_we;

    // Shared address bus: row in the row phase, column in the column phase.
    always_comb begin
        addr = '0;
        if (state == ST_ROW) begin
            addr[ROW_W-1:0] = cur_row;
        end else if (state == ST_COL) begin
            addr[COL_W-1:0] = cur_col;
        end
    end

    // Phase sequencing and open-row bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            row_open <= 1'b0;
            open_row <= '0;
            cur_row  <= '0;
            cur_col  <= '0;
            cur_we   <= 1'b0;
            serving  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ref_pending) begin
                        serving <= 1'b0;
                        state   <= row_open ? ST_WB : ST_REF;
                    end else if (req_valid) begin
                        serving <= 1'b1;
                        cur_row <= in_row;
                        cur_col <= req_index[COL_W-1:0];
                        cur_we  <= req_write;
                        if (row_open && open_row == in_row) begin
                            state <= ST_COL;
                        end else if (row_open) begin
                            state <= ST_WB;
                        end else begin
                            state <= ST_ROW;
                        end
                    end
                end
                ST_WB: begin
                    row_open <= 1'b0;
                    state    <= serving ? ST_ROW : ST_REF;
                end
                ST_ROW: begin
                    row_open <= 1'b1;
                    open_row <= cur_row;
                    state    <= ST_COL;
                end
                ST_COL: begin
                    serving <= 1'b0;
                    state   <= ST_IDLE;
                end
                ST_REF: begin
                    row_open <= 1'b0;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Read response pulse in the cycle after the column read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= (state == ST_COL) && !cur_we;
        end
    end

    logic unused_accept;
    assign unused_accept = accept;
endmodule

// File: rtl/mux_dram_top.sv
// Top level: one controller, one refresh timer and LANES identical arrays
// ganged into a WORD_W-bit word. Lane i holds word bits [i*LANE_W +: LANE_W].
// All lanes see the same commands and address.
module mux_dram_top
    import mux_dram_pkg::*;
#(
    parameter  int unsigned ROWS             = 4,
    parameter  int unsigned COLS             = 4,
    parameter  int unsigned LANE_W           = 8,
    parameter  int unsigned LANES            = 8,
    parameter  int unsigned REFRESH_INTERVAL = 64,
    localparam int unsigned ROW_W            = $clog2(ROWS),
    localparam int unsigned COL_W            = $clog2(COLS),
    localparam int unsigned IDX_W            = ROW_W + COL_W,
    localparam int unsigned BUS_W            = wmax(ROW_W, COL_W),
    localparam int unsigned WORD_W           = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_index,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              row_strobe,
    output logic              col_strobe,
    output logic              wb_strobe,
    output logic              ref_strobe,
    output logic [BUS_W-1:0]  addr_bus
);
    logic ref_pending;
    logic ref_done;
    logic wr_en;

    assign ref_strobe = ref_done;

    mux_dram_refresh #(.INTERVAL(REFRESH_INTERVAL)) u_refresh (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_done    (ref_done),
        .ref_pending (ref_pending)
    );

    mux_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .BUS_W(BUS_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_index   (req_index),
        .ref_pending (ref_pending),
        .ref_done    (ref_done),
        .row_cmd     (row_strobe),
        .col_cmd     (col_strobe),
        .wb_cmd      (wb_strobe),
        .wr_en       (wr_en),
        .addr        (addr_bus),
        .rsp_valid   (rsp_valid)
    );

    // One array per byte lane; all share commands and address.
    for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
        mux_dram_array #(.ROWS(ROWS), .COLS(COLS), .W(LANE_W), .BUS_W(BUS_W)) u_array (
            .clk     (clk),
            .rst_n   (rst_n),
            .row_cmd (row_strobe),
            .col_cmd (col_strobe),
            .wb_cmd  (wb_strobe),
            .wr_en   (wr_en),
            .addr    (addr_bus),
            .din     (req_wdata_q[g*LANE_W +: LANE_W]),
            .dout    (rsp_rdata[g*LANE_W +: LANE_W])
        );
    end

    // Hold write data from acceptance until the column write.
    logic [WORD_W-1:0] req_wdata_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_wdata_q <= '0;
        end else if (req_valid && req_ready) begin
            req_wdata_q <= req_wdata;
        end
    end
endmodule

// File: rtl/mux_dram_checker.sv
// Protocol checker bound to mux_dram_top. Tracks whether a row is open from
// the command outputs alone and checks ordering, pulses and refresh spacing.
module mux_dram_checker #(
    parameter int unsigned REFRESH_INTERVAL = 64
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic row_strobe,
    input logic col_strobe,
    input logic wb_strobe,
    input logic ref_strobe
);
    localparam int unsigned GAP_MAX = REFRESH_INTERVAL + 6;
    localparam int unsigned GAP_W   = $clog2(GAP_MAX + 2) + 1;

    logic             row_live;
    logic [GAP_W-1:0] gap;

    // Open-row shadow derived from commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_live <= 1'b0;
        end else if (row_strobe) begin
            row_live <= 1'b1;
        end else if (wb_strobe || ref_strobe) begin
            row_live <= 1'b0;
        end
    end

    // Cycles since the last refresh, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || ref_strobe) begin
            gap <= '0;
        end else if (gap != {GAP_W{1'b1}}) begin
            gap <= gap + 1'b1;
        end
    end

    a_r2_one_command: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({row_strobe, col_strobe, wb_strobe, ref_strobe}));

    a_r1_col_needs_open_row: assert property (@(posedge clk) disable iff (!rst_n)
        col_strobe |-> row_live);

    a_r6_row_only_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        row_strobe |-> !row_live);

    a_r3_rsp_after_col: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(col_strobe));

    a_r3_rsp_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r7_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !(row_strobe || col_strobe || wb_strobe || ref_strobe));

    a_r7_ready_drops_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r8_refresh_on_closed_row: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe |-> !row_live);

    a_r8_refresh_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        gap <= GAP_W'(GAP_MAX));
endmodule

bind mux_dram_top mux_dram_checker #(.REFRESH_INTERVAL(REFRESH_INTERVAL)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .row_strobe (row_strobe),
    .col_strobe (col_strobe),
    .wb_strobe  (wb_strobe),
    .ref_strobe (ref_strobe)
);

// File: tb/tb_mux_dram_top.sv
// Self-checking bench: directed corner cases plus a seeded random stream,
// with expected data, command counts and latencies from a bench model.
module tb_mux_dram_top;
    localparam int ROWS     = 4;
    localparam int COLS     = 4;
    localparam int COL_W    = 2;
    localparam int IDX_W    = 4;
    localparam int BUS_W    = 2;
    localparam int WORD_W   = 64;
    localparam int INTERVAL = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [IDX_W-1:0]  req_index = '0;
    logic [WORD_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [WORD_W-1:0] rsp_rdata;
    logic              row_strobe, col_strobe, wb_strobe, ref_strobe;
    logic [BUS_W-1:0]  addr_bus;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc = 0;
    int last_ref = 0;
    int n_refs = 0;
    int collisions = 0;
    bit open_m = 1'b0;
    int open_row_m = 0;
    bit prev_wb = 1'b0;
    bit after_ref = 1'b0;
    logic [WORD_W-1:0] model [ROWS*COLS];

    always #4 clk = ~clk;

    mux_dram_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_index(req_index), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .row_strobe(row_strobe),
        .col_strobe(col_strobe), .wb_strobe(wb_strobe), .ref_strobe(ref_strobe),
        .addr_bus(addr_bus)
    );

    task automatic check(input bit ok, input string req, input logic [WORD_W-1:0] act,
                         input logic [WORD_W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance to the next falling edge and watch refresh activity.
    task automatic tick();
        @(negedge clk);
        cyc++;
        if (ref_strobe) begin
            check(cyc - last_ref <= INTERVAL + 6, "R8 refresh gap", cyc - last_ref, INTERVAL + 6);
            if (open_m) check(prev_wb, "R8 write-back before refresh", prev_wb, 1);
            if (req_valid) collisions++;
            open_m    = 1'b0;
            after_ref = 1'b1;
            last_ref  = cyc;
            n_refs++;
        end
        prev_wb = wb_strobe;
    endtask

    task automatic do_req(input bit we, input int idx, input logic [WORD_W-1:0] d);
        int row, col, n, nr, nw;
        bit exp_row, exp_wb, fresh;
        string tag;
        row = idx / COLS;
        col = idx % COLS;
        req_write = we; req_index = IDX_W'(idx); req_wdata = d; req_valid = 1'b1;
        while (!req_ready) tick();
        exp_row = !(open_m && open_row_m == row);
        exp_wb  = open_m && open_row_m != row;
        fresh   = after_ref;
        after_ref  = 1'b0;
        open_m     = 1'b1;
        open_row_m = row;
        tag = fresh ? "R8 row after refresh" : (exp_wb ? "R6 row change" : (exp_row ? "R1 closed row" : "R5 row hit"));
        @(posedge clk);
        tick();
        req_valid = 1'b0;
        check(!req_ready, "R7 ready low after accept", req_ready, 0);
        n = 1; nr = 0; nw = 0;
        while (n < 10) begin
            if (row_strobe) begin
                nr++;
                check(addr_bus == BUS_W'(row), "R2 row on address bus", addr_bus, row);
            end
            if (wb_strobe) nw++;
            if (col_strobe) begin
                check(addr_bus == BUS_W'(col), "R2 column on address bus", addr_bus, col);
                check(!rsp_valid, "R3 no response in column cycle", rsp_valid, 0);
                break;
            end
            tick();
            n++;
        end
        check(n == 1 + int'(exp_row) + int'(exp_wb), {tag, " latency"}, n, 1 + exp_row + exp_wb);
        check(nr == int'(exp_row), {tag, " row strobes"}, nr, exp_row);
        check(nw == int'(exp_wb), {tag, " write-backs"}, nw, exp_wb);
        if (we) begin
            model[idx] = d;
        end else begin
            tick();
            check(rsp_valid, "R3 response pulse", rsp_valid, 1);
            check(rsp_rdata === model[idx], "R4 read data", rsp_rdata, model[idx]);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) tick();
        rst_n = 1'b1;
        last_ref = cyc;
        tick();
        // R1: reset state.
        check(req_ready && !rsp_valid, "R1 reset handshake", {req_ready, rsp_valid}, 2'b10);
        check({row_strobe, col_strobe, wb_strobe, ref_strobe} == 4'b0, "R1 reset strobes",
              {row_strobe, col_strobe, wb_strobe, ref_strobe}, 0);
        // Fill every index; all lanes distinct (R4).
        for (int i = 0; i < ROWS*COLS; i++) begin
            do_req(1'b1, i, {8'(i), 8'hA5, 8'(i*3), 8'h5A, 8'(~i), 8'h0F, 8'(i*7), 8'hF0});
        end
        // Sequential reads: row hits (R5), then row changes (R6).
        for (int i = 0; i < ROWS*COLS; i++) do_req(1'b0, i, '0);
        for (int i = 0; i < 8; i++) do_req(1'b0, (i % 2 == 0) ? 1 : 14, '0);
        // Write, leave the row, return (R6 write-back survives).
        do_req(1'b1, 6, 64'hDEAD_BEEF_0123_4567);
        do_req(1'b0, 9, '0);
        do_req(1'b0, 6, '0);
        do_req(1'b1, 0, '1);
        do_req(1'b1, 15, '0);
        do_req(1'b0, 0, '0);
        do_req(1'b0, 15, '0);
        // Seeded random stream, back to back (R9 collisions arise here).
        for (int k = 0; k < 500; k++) begin
            int idx;
            if ($urandom % 3 == 0) idx = open_row_m * COLS + int'($urandom % COLS);
            else idx = int'($urandom % (ROWS*COLS));
            do_req(1'($urandom % 2), idx, {$urandom, $urandom});
        end
        repeat (INTERVAL + 8) tick();
        check(n_refs > 0, "R8 refresh seen", n_refs, 1);
        check(collisions > 0, "R9 refresh beat waiting request", collisions, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule